// File: doc/BRIEF.md
# AXI Write Master Behaviour Monitor

This block sits beside the write port of an AXI link and watches the write address (AW), write data (W) and write response (B) channels without driving any of them. It decides, cycle by cycle, whether the master on that port behaves well. A well-behaved master provides data no later than its address. It lets data run at most one whole burst ahead of the address that belongs to it. It keeps a data burst going without gaps, always accepts responses, and holds valid signals and their payloads steady until the handshake completes.

Each rule has its own sticky flag. A flag stays set until a synchronous reset clears it, so a breach that lasted a single cycle is still visible long afterwards. A combined pulse marks every cycle in which a new breach was seen, so it can feed an interrupt or a trace trigger. Data width, address width, ID width, burst length width and the width of the burst balance counter are all parameters.

Internally, a signed balance counts completed data bursts minus completed address transfers. The balance is what lets the monitor tell a legal case apart from an illegal one: an address that waits alone is legal when its data burst already sits in buffering, and illegal when no such burst exists.

Top module: `axi_wr_master_mon`

## Requirements
- R1: While `rst` is high at a rising edge, all six bits of `breach_flags` and `breach_pulse` are cleared to 0 by that edge.
- R2: Bit 0 of `breach_flags` (ordering) is set when `aw_valid` is high and `w_valid` is low in a cycle in which the burst balance (completed W bursts minus completed AW transfers) is zero or below. When the balance is one or more, an address presented alone is legal.
- R3: Bit 1 of `breach_flags` (lead) is set when a W beat with `w_last` completes and this brings the burst balance above one. A lead of exactly one burst is legal.
- R4: Bit 2 of `breach_flags` (gap) is set when `w_valid` was high in the previous cycle, that cycle had no completed `w_last` beat, and `w_valid` is now low.
- R5: Bit 3 of `breach_flags` (response) is set in any cycle where `b_ready` is low.
- R6: Bit 4 of `breach_flags` (address hold) is set when AW was valid and not accepted in the previous cycle and now either `aw_valid` is low or any of `aw_addr`, `aw_id`, `aw_len` differs.
- R7: Bit 5 of `breach_flags` (data hold) is set when W was valid and not accepted in the previous cycle, `w_valid` is still high, and `w_data` or `w_last` differs.
- R8: Every flag bit, once set, stays set until reset. `breach_pulse` is high in the cycle after each cycle that contained at least one breach, and low after a cycle without one. Flags and pulse change on the rising edge that samples the offending cycle.
- R9: Legal traffic raises no flag and no pulse. This covers any mix of ready stalls, data sent with its address, and data sent one whole burst ahead of its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the monitored port |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_addr | input | ADDR_W | Address payload |
| aw_id | input | ID_W | Transaction ID payload |
| aw_len | input | LEN_W | Burst length payload |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_data | input | DATA_W | Write data payload |
| w_last | input | 1 | Last beat of a burst |
| b_valid | input | 1 | Response channel valid (observed only) |
| b_ready | input | 1 | Response channel ready |
| breach_flags | output | 6 | Sticky per-rule breach flags, bit order as in R2 to R7 |
| breach_pulse | output | 1 | High for the cycle after any breach |

## Verification
Random legal bursts are applied with random ready stalls. Some send data alongside the address and some send a whole burst before it. This shows that the ordering and lead checks accept every legal interleaving. Directed cases then break one rule at a time, and each case must set exactly its own flag bit. This separates a dropped valid from a changed payload, and it separates a gap in a data burst from a data stall. A one-burst lead followed by a lone address has to stay silent, while a two-burst lead has to trip the lead bit. This pins both edges of the balance window. Idle cycles after a breach, and two breaches without a reset between them, show that the flags are sticky and that the pulse lasts a single cycle.

// File: rtl/wmon_pkg.sv
package wmon_pkg;
  localparam int unsigned RULE_CNT    = 6;
  localparam int unsigned RULE_ORDER  = 0;
  localparam int unsigned RULE_LEAD   = 1;
  localparam int unsigned RULE_GAP    = 2;
  localparam int unsigned RULE_BREADY = 3;
  localparam int unsigned RULE_AWHOLD = 4;
  localparam int unsigned RULE_WHOLD  = 5;
endpackage

// File: rtl/wmon_hold_check.sv
// Generic ready/valid stability checker for one channel.
module wmon_hold_check #(
  parameter int unsigned PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             ready,
  input  logic [PAY_W-1:0] payload,
  output logic             drop_hit,
  output logic             change_hit
);
  logic             pend_q;
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pay_q  <= '0;
    end else begin
      pend_q <= valid & ~ready;
      pay_q  <= payload;
    end
  end

  always_comb begin
    drop_hit   = pend_q & ~valid;
    change_hit = pend_q & valid & (payload != pay_q);
  end
endmodule

// File: rtl/wmon_write_order.sv
// Burst balance tracking, address/data ordering and data-gap detection.
module wmon_write_order #(
  parameter int unsigned BAL_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic aw_valid,
  input  logic aw_ready,
  input  logic w_valid,
  input  logic w_ready,
  input  logic w_last,
  output logic order_hit,
  output logic lead_hit,
  output logic gap_hit
);
  localparam logic signed [BAL_W-1:0] BAL_MAX = {1'b0, {(BAL_W-1){1'b1}}};
  localparam logic signed [BAL_W-1:0] BAL_MIN = {1'b1, {(BAL_W-1){1'b0}}};
  localparam logic signed [BAL_W-1:0] BAL_ONE = {{(BAL_W-1){1'b0}}, 1'b1};

  logic signed [BAL_W-1:0] bal_q, bal_d;
  logic w_active_q;
  logic aw_fire, burst_done;

  always_comb begin
    aw_fire    = aw_valid & aw_ready;
    burst_done = w_valid & w_ready & w_last;
    bal_d      = bal_q;
    if (burst_done && !aw_fire && bal_q != BAL_MAX) bal_d = bal_q + BAL_ONE;
    else if (aw_fire && !burst_done && bal_q != BAL_MIN) bal_d = bal_q - BAL_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bal_q      <= '0;
      w_active_q <= 1'b0;
    end else begin
      bal_q      <= bal_d;
      w_active_q <= w_valid & ~(w_ready & w_last);
    end
  end

  always_comb begin
    order_hit = aw_valid & ~w_valid & (bal_q <= $signed({BAL_W{1'b0}}));
    lead_hit  = burst_done & (bal_d > BAL_ONE);
    gap_hit   = w_active_q & ~w_valid;
  end

  // R3: completing a second buffered burst must be reported
  assert_lead_R3: assert property (@(posedge clk) disable iff (rst)
    (bal_q == BAL_ONE && burst_done && !aw_fire) |-> lead_hit);

  // R2: ordering breach only ever reported with a lone address
  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    order_hit |-> (aw_valid && !w_valid));
endmodule

// File: rtl/wmon_flag_bank.sv
// Sticky breach flags and combined one-cycle pulse.
module wmon_flag_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hits,
  output logic [N-1:0] flags,
  output logic         pulse
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      pulse   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      flags   <= flags | hits;
      pulse   <= |hits;
      past_ok <= 1'b1;
    end
  end

  // R8: a flag never clears outside reset
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((flags & $past(flags)) == $past(flags)));

  // R8: a pulse always comes with at least one flag
  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (flags != '0));
endmodule

// File: rtl/axi_wr_master_mon.sv
module axi_wr_master_mon
  import wmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BAL_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [LEN_W-1:0]    aw_len,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic                w_last,
  input  logic                b_valid,
  input  logic                b_ready,
  output logic [RULE_CNT-1:0] breach_flags,
  output logic                breach_pulse
);
  localparam int unsigned AW_PAY_W = ADDR_W + ID_W + LEN_W;
  localparam int unsigned W_PAY_W  = DATA_W + 1;

  logic aw_drop, aw_change, w_drop_unused, w_change;
  logic order_hit, lead_hit, gap_hit;
  logic [RULE_CNT-1:0] hits;
  logic b_seen_unused;

  assign b_seen_unused = b_valid;

  wmon_hold_check #(.PAY_W(AW_PAY_W)) u_aw_hold (
    .clk(clk), .rst(rst), .valid(aw_valid), .ready(aw_ready),
    .payload({aw_id, aw_addr, aw_len}),
    .drop_hit(aw_drop), .change_hit(aw_change)
  );

  // W valid drops are covered by the stronger burst-gap rule
  wmon_hold_check #(.PAY_W(W_PAY_W)) u_w_hold (
    .clk(clk), .rst(rst), .valid(w_valid), .ready(w_ready),
    .payload({w_last, w_data}),
    .drop_hit(w_drop_unused), .change_hit(w_change)
  );

  wmon_write_order #(.BAL_W(BAL_W)) u_order (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .order_hit(order_hit), .lead_hit(lead_hit), .gap_hit(gap_hit)
  );

  always_comb begin
    hits              = '0;
    hits[RULE_ORDER]  = order_hit;
    hits[RULE_LEAD]   = lead_hit;
    hits[RULE_GAP]    = gap_hit;
    hits[RULE_BREADY] = ~b_ready;
    hits[RULE_AWHOLD] = aw_drop | aw_change;
    hits[RULE_WHOLD]  = w_change;
  end

  wmon_flag_bank #(.N(RULE_CNT)) u_flags (
    .clk(clk), .rst(rst), .hits(hits),
    .flags(breach_flags), .pulse(breach_pulse)
  );

  // R5: a stalled response channel is flagged on the next cycle
  assert_bready_R5: assert property (@(posedge clk) disable iff (rst)
    !b_ready |=> breach_flags[RULE_BREADY]);

  // R6: withdrawing a pending address is flagged
  assert_awdrop_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(aw_valid && !aw_ready) && !aw_valid) |=> breach_flags[RULE_AWHOLD]);

  // R4: a gap inside a data burst is flagged
  assert_wgap_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(w_valid && !(w_ready && w_last)) && !w_valid) |=> breach_flags[RULE_GAP]);
endmodule

// File: tb/sim_axi_wr_master_mon.sv
`timescale 1ns/1ps
module sim_axi_wr_master_mon;
  logic        clk = 1'b0;
  logic        rst;
  logic        aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic [31:0] aw_addr, w_data;
  logic [3:0]  aw_id;
  logic [7:0]  aw_len;
  logic [5:0]  breach_flags;
  logic        breach_pulse;
  int          n_tests = 0;
  int          n_fail  = 0;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  axi_wr_master_mon u0 (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .breach_flags(breach_flags), .breach_pulse(breach_pulse)
  );

  function automatic logic [5:0] rule_mask(input int bitpos);
    return 6'(1 << bitpos);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    aw_valid = 1'b0; w_valid = 1'b0; w_last = 1'b0;
    aw_ready = 1'b0; w_ready = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    b_ready = 1'b1; b_valid = 1'b0;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  // Legal burst: mode 0 sends data with address, mode 1 sends data first
  task automatic legal_burst(input int mode, input int len);
    int  beat = 0;
    bit  aw_done = 0, w_done = 0;
    aw_addr = $urandom; aw_id = 4'($urandom); aw_len = 8'(len - 1);
    w_data = $urandom; w_last = (len == 1);
    b_valid = 1'($urandom);
    if (mode == 1) begin
      w_valid = 1'b1;
      while (!w_done) begin
        w_ready = 1'($urandom);
        step();
        if (w_ready) begin
          if (w_last) w_done = 1;
          else begin beat++; w_data = $urandom; w_last = (beat == len - 1); end
        end
      end
      w_valid = 1'b0; w_last = 1'b0; w_ready = 1'b0;
      aw_valid = 1'b1;
      while (!aw_done) begin
        aw_ready = 1'($urandom);
        step();
        if (aw_ready) aw_done = 1;
      end
      aw_valid = 1'b0; aw_ready = 1'b0;
    end else begin
      aw_valid = 1'b1; w_valid = 1'b1;
      while (!(aw_done && w_done)) begin
        aw_ready = aw_done ? 1'b0 : 1'($urandom);
        w_ready  = w_done ? 1'b0 : 1'($urandom);
        step();
        if (aw_valid && aw_ready) begin aw_done = 1; aw_valid = 1'b0; end
        if (w_valid && w_ready) begin
          if (w_last) begin w_done = 1; w_valid = 1'b0; w_last = 1'b0; end
          else begin beat++; w_data = $urandom; w_last = (beat == len - 1); end
        end
      end
      aw_ready = 1'b0; w_ready = 1'b0;
    end
    repeat ($urandom % 3) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    aw_addr = '0; aw_id = '0; aw_len = '0; w_data = '0;
    do_reset();
    chk("R1 flags after reset", 32'(breach_flags), 0);
    chk("R1 pulse after reset", 32'(breach_pulse), 0);

    // R9: random legal traffic in both orderings
    for (int i = 0; i < 48; i++) begin
      legal_burst(int'($urandom % 2), int'($urandom % 4) + 1);
      if (i % 8 == 7) begin
        chk("R9 legal traffic flags", 32'(breach_flags), 0);
        chk("R9 legal traffic pulse", 32'(breach_pulse), 0);
      end
    end

    // R2: lone address with no buffered data
    do_reset();
    aw_valid = 1'b1; aw_ready = 1'b1; w_valid = 1'b0;
    step();
    idle();
    chk("R2 ordering flag", 32'(breach_flags), 32'(rule_mask(0)));
    chk("R8 pulse after breach", 32'(breach_pulse), 1);
    step();
    chk("R8 pulse one cycle", 32'(breach_pulse), 0);
    repeat (3) step();
    chk("R8 flag sticky", 32'(breach_flags), 32'(rule_mask(0)));
    do_reset();
    chk("R1 reset clears sticky flag", 32'(breach_flags), 0);

    // R3: one burst ahead is legal, lone address then exempt, two ahead is not
    w_valid = 1'b1; w_last = 1'b1; w_ready = 1'b1;
    step();
    idle(); step();
    chk("R3 one burst ahead legal", 32'(breach_flags), 0);
    aw_valid = 1'b1; aw_ready = 1'b1;
    step();
    idle(); step();
    chk("R2 lone address with buffered burst legal", 32'(breach_flags), 0);
    w_valid = 1'b1; w_last = 1'b1; w_ready = 1'b1;
    step(); step();
    idle(); step();
    chk("R3 two bursts ahead flag", 32'(breach_flags), 32'(rule_mask(1)));

    // R4: gap inside a data burst
    do_reset();
    w_valid = 1'b1; w_last = 1'b0; w_ready = 1'b1;
    step();
    w_valid = 1'b0; w_ready = 1'b0;
    step();
    chk("R4 burst gap flag", 32'(breach_flags), 32'(rule_mask(2)));

    // R5 on top of R4 without reset: flags accumulate
    b_ready = 1'b0;
    step();
    b_ready = 1'b1;
    chk("R5 response stall flag", 32'(breach_flags), 32'(rule_mask(2) | rule_mask(3)));
    chk("R8 pulse on second breach", 32'(breach_pulse), 1);

    // R6: payload change while pending
    do_reset();
    aw_valid = 1'b1; w_valid = 1'b1; w_last = 1'b0; aw_ready = 1'b0; w_ready = 1'b0;
    step();
    aw_addr = aw_addr ^ 32'h1;
    step();
    chk("R6 address change flag", 32'(breach_flags), 32'(rule_mask(4)));

    // R6: valid withdrawn while pending
    do_reset();
    aw_valid = 1'b1; w_valid = 1'b1; w_last = 1'b0; aw_ready = 1'b0; w_ready = 1'b0;
    step();
    aw_valid = 1'b0;
    step();
    chk("R6 address drop flag", 32'(breach_flags), 32'(rule_mask(4)));

    // R7: data change while pending
    do_reset();
    w_valid = 1'b1; w_last = 1'b0; w_ready = 1'b0;
    step();
    w_data = w_data ^ 32'h80;
    step();
    chk("R7 data change flag", 32'(breach_flags), 32'(rule_mask(5)));

    // R7: last marker change while pending
    do_reset();
    w_valid = 1'b1; w_last = 1'b0; w_ready = 1'b0;
    step();
    w_last = 1'b1;
    step();
    chk("R7 last change flag", 32'(breach_flags), 32'(rule_mask(5)));

    do_reset();
    chk("R1 final reset", 32'(breach_flags), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule